// File: doc/BRIEF.md
# Multi-Cycle Register-Memory Processor Core

A small stored-program processor that keeps instructions and data in one memory behind a single port. It has four general-purpose registers of one data word each, and a program counter that starts at word 0. Every instruction runs through the same sequence of clocked steps. First the word at the program counter is fetched into an instruction register and the counter advances. Next the opcode is decoded. Last the memory access, branch decision or two-step arithmetic is carried out. Integers are two's complement.

The memory port gives a word address, a write strobe, write data and read data. Read data is combinational: the memory must present the word at `mem_addr_o` within the same cycle. A write takes effect at the rising edge on which `mem_we_o` is high. When a program reaches a stop instruction, or an opcode that has no meaning, the core raises `halted_o` and stays there until reset.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_ni` is low, `halted_o` is 0, `mem_we_o` is 0 and `mem_addr_o` is 0. All registers reset to 0, and the first fetch after reset reads word 0.
- R2: Each instruction is fetched from the program counter, with `mem_we_o` low. The counter then steps by one, wrapping from the last word of the address space to word 0.
- R3: The instruction word holds the opcode in bits [15:12], the register Rn in bits [11:10] and the word address in bits [9:0]. For the indirect forms, the register Rm is given by bits [1:0].
- R4: Opcode 0001 loads Rn from memory at the address field. Opcode 0010 writes Rn to memory at the address field with `mem_we_o` high for exactly one cycle.
- R5: Opcode 0011 sets Rn to Rn plus memory, and opcode 0100 sets Rn to Rn minus memory. Both wrap modulo 2^16.
- R6: Opcode 0101 jumps unconditionally to the address field.
- R7: Opcode 0110 jumps to the address field when Rn is zero. Opcode 0111 jumps when bit 15 of Rn is set. Otherwise both fall through to the next word.
- R8: Opcodes 1001 (load), 1010 (store), 1011 (add) and 1100 (subtract) behave like their direct forms. Their memory address is instead bits [9:0] of register Rm.
- R9: Opcode 0000, and the unused opcodes 1000 and 1101 to 1111, raise `halted_o` permanently. After that no write occurs and `mem_addr_o` stays frozen at the word after the halting instruction.
- R10: Loads, stores and jumps, taken or not, take 3 cycles. Add and subtract take 5 cycles: fetch, decode, operand capture, ALU, write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 10 | Word address for the fetch or the operand |
| mem_we_o | output | 1 | Write strobe, 1 = write, 0 = read |
| mem_wdata_o | output | 16 | Store data (register Rn) |
| mem_rdata_i | input | 16 | Read data at `mem_addr_o`, same cycle |
| halted_o | output | 1 | Core has stopped |

## Verification
The bench builds the core with its default parameters: a 16-bit word and four registers. These give a 10-bit address field and a full 1024-word space, so the wrap of the program counter from word 1023 to word 0 can be tested directly. Within that space it runs a repeated-addition multiply with random multiplicands and counts, including zero and negative counts. It also runs a pointer-walking vector sum over random data and lengths. Directed programs cover the indirect store and subtract, branches on the most negative and most positive values, every halting opcode, and the cycle cost per loop iteration.

// File: rtl/cpu_pkg.sv
package cpu_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_STOP = 4'h0;
  localparam logic [OPC_W-1:0] OPC_LD   = 4'h1;
  localparam logic [OPC_W-1:0] OPC_ST   = 4'h2;
  localparam logic [OPC_W-1:0] OPC_ADD  = 4'h3;
  localparam logic [OPC_W-1:0] OPC_SUB  = 4'h4;
  localparam logic [OPC_W-1:0] OPC_GOTO = 4'h5;
  localparam logic [OPC_W-1:0] OPC_JZ   = 4'h6;
  localparam logic [OPC_W-1:0] OPC_JN   = 4'h7;
  localparam logic [OPC_W-1:0] OPC_LDI  = 4'h9;
  localparam logic [OPC_W-1:0] OPC_STI  = 4'hA;
  localparam logic [OPC_W-1:0] OPC_ADDI = 4'hB;
  localparam logic [OPC_W-1:0] OPC_SUBI = 4'hC;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEC, ST_ALU, ST_WB, ST_HALT
  } state_e;

  typedef struct packed {
    logic halt;
    logic load;
    logic store;
    logic arith;
    logic sub;
    logic jmp;
    logic jz;
    logic jn;
    logic ind;
  } ctl_t;
endpackage

// File: rtl/cpu_decode.sv
module cpu_decode
  import cpu_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output ctl_t             ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (opc_i)
      OPC_LD:   ctl_o.load  = 1'b1;
      OPC_ST:   ctl_o.store = 1'b1;
      OPC_ADD:  ctl_o.arith = 1'b1;
      OPC_SUB:  begin ctl_o.arith = 1'b1; ctl_o.sub = 1'b1; end
      OPC_GOTO: ctl_o.jmp   = 1'b1;
      OPC_JZ:   ctl_o.jz    = 1'b1;
      OPC_JN:   ctl_o.jn    = 1'b1;
      OPC_LDI:  begin ctl_o.load  = 1'b1; ctl_o.ind = 1'b1; end
      OPC_STI:  begin ctl_o.store = 1'b1; ctl_o.ind = 1'b1; end
      OPC_ADDI: begin ctl_o.arith = 1'b1; ctl_o.ind = 1'b1; end
      OPC_SUBI: begin ctl_o.arith = 1'b1; ctl_o.sub = 1'b1; ctl_o.ind = 1'b1; end
      default:  ctl_o.halt  = 1'b1; // STOP and unused codes
    endcase
  end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4,
  parameter int PTR_W    = 10,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [REG_W-1:0]  raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [REG_W-1:0]  raddr_b_i,
  output logic [PTR_W-1:0]  rdata_b_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             regs_q[g] <= '0;
      else if (we_i && waddr_i == REG_W'(g))   regs_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs_q[raddr_a_i];
  assign rdata_b_o = regs_q[raddr_b_i][PTR_W-1:0];
endmodule

// File: rtl/cpu_alu.sv
module cpu_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] y_o
);
  assign y_o = sub_i ? (a_i - b_i) : (a_i + b_i);
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import cpu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4,
  localparam int REG_W   = $clog2(NUM_REGS),
  localparam int ADDR_W  = DATA_W - OPC_W - REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              halted_o
);
  state_e            state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q, alu_a_q, alu_b_q, alu_y_q;
  ctl_t              ctl_q, ctl_d;

  logic [OPC_W-1:0]  f_opc;
  logic [REG_W-1:0]  f_rn, f_rm;
  logic [ADDR_W-1:0] f_addr, eff_addr, ptr;
  logic [DATA_W-1:0] rn_val, alu_y, rf_wdata;
  logic              rf_we, take;

  assign f_opc  = ir_q[DATA_W-1 -: OPC_W];
  assign f_rn   = ir_q[ADDR_W +: REG_W];
  assign f_addr = ir_q[ADDR_W-1:0];
  assign f_rm   = ir_q[REG_W-1:0];

  cpu_decode u_dec (.opc_i(f_opc), .ctl_o(ctl_d));

  assign rf_we    = (state_q == ST_WB) || (state_q == ST_EXEC && ctl_q.load);
  assign rf_wdata = (state_q == ST_WB) ? alu_y_q : mem_rdata_i;

  cpu_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .PTR_W(ADDR_W)) u_rf (
    .clk_i, .rst_ni,
    .we_i(rf_we), .waddr_i(f_rn), .wdata_i(rf_wdata),
    .raddr_a_i(f_rn), .rdata_a_o(rn_val),
    .raddr_b_i(f_rm), .rdata_b_o(ptr)
  );

  cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i(alu_a_q), .b_i(alu_b_q), .sub_i(ctl_q.sub), .y_o(alu_y)
  );

  assign eff_addr = ctl_q.ind ? ptr : f_addr;
  assign take     = ctl_q.jmp | (ctl_q.jz & ~|rn_val) | (ctl_q.jn & rn_val[DATA_W-1]);

  assign mem_addr_o  = (state_q == ST_EXEC) ? eff_addr : pc_q;
  assign mem_we_o    = (state_q == ST_EXEC) && ctl_q.store;
  assign mem_wdata_o = rn_val;
  assign halted_o    = (state_q == ST_HALT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      ctl_q   <= '0;
      alu_a_q <= '0;
      alu_b_q <= '0;
      alu_y_q <= '0;
    end else begin
      unique case (state_q)
        ST_FETCH: begin
          ir_q    <= mem_rdata_i;
          pc_q    <= pc_q + ADDR_W'(1);
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          ctl_q   <= ctl_d;
          state_q <= ctl_d.halt ? ST_HALT : ST_EXEC;
        end
        ST_EXEC: begin
          if (take) pc_q <= f_addr;
          if (ctl_q.arith) begin
            alu_a_q <= rn_val;
            alu_b_q <= mem_rdata_i;
            state_q <= ST_ALU;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        ST_ALU: begin
          alu_y_q <= alu_y;
          state_q <= ST_WB;
        end
        ST_WB:   state_q <= ST_FETCH;
        default: state_q <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/acc_cpu_sva.sv
module acc_cpu_sva
  import cpu_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] mem_addr_i,
  input logic              mem_we_i,
  input logic              halted_i,
  input state_e            state_i,
  input logic [ADDR_W-1:0] pc_i
);
  // R4: a store strobes for a single cycle
  a_r4_we_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_i |=> !mem_we_i);

  // R2: fetch never writes and advances the counter by one
  a_r2_fetch_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FETCH) |-> !mem_we_i);
  a_r2_pc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_FETCH) |=> (pc_i == $past(pc_i) + ADDR_W'(1)));

  // R9: halt is sticky, silent and frozen
  a_r9_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> halted_i);
  a_r9_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |-> !mem_we_i);
  a_r9_addr_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> $stable(mem_addr_i));

  // R10: arithmetic passes ALU then write-back before the next fetch
  a_r10_alu_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ALU) |=> (state_i == ST_WB));
  a_r10_wb_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WB) |=> (state_i == ST_FETCH));
endmodule

bind acc_cpu acc_cpu_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_addr_i (mem_addr_o),
  .mem_we_i   (mem_we_o),
  .halted_i   (halted_o),
  .state_i    (state_q),
  .pc_i       (pc_q)
);

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;
  localparam int DW = 16;
  localparam int AW = 10;
  localparam int MEM_N = 1 << AW;
  localparam int RUN_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_we;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          halted;

  logic [DW-1:0] mem [MEM_N];
  logic          clr = 1'b0, ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  acc_cpu dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_addr_o(mem_addr), .mem_we_o(mem_we), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .halted_o(halted)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < MEM_N; i++) mem[i] <= '0;
    end else if (ld_en) begin
      mem[ld_addr] <= ld_data;
    end else if (rst_n && mem_we) begin
      mem[mem_addr] <= mem_wdata;
    end
  end

  function automatic logic [DW-1:0] enc(input logic [3:0] op, input int rn, input int addr);
    return {op, 2'(rn), 10'(addr)};
  endfunction

  function automatic logic [DW-1:0] mul_ref(input logic [DW-1:0] b, input logic [DW-1:0] c);
    logic [DW-1:0] acc = '0;
    if ($signed(c) <= 0) return '0;
    for (int i = 0; i < int'(c); i++) acc = acc + b;
    return acc;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [DW-1:0] d);
    ld_en = 1'b1; ld_addr = AW'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic run(output int cyc);
    cyc = 0;
    rst_n = 1'b1;
    while (!halted && cyc < RUN_LIMIT) begin
      @(negedge clk);
      cyc++;
    end
    check(halted == 1'b1, "R9 watchdog/halt reached", cyc, RUN_LIMIT);
  endtask

  task automatic load_mult(input logic [DW-1:0] b, input logic [DW-1:0] c);
    hold_reset();
    poke(0, enc(4'h1, 1, 'h200));
    poke(1, enc(4'h1, 2, 'h102));
    poke(2, enc(4'h6, 2, 7));
    poke(3, enc(4'h7, 2, 7));
    poke(4, enc(4'h3, 1, 'h101));
    poke(5, enc(4'h4, 2, 'h201));
    poke(6, enc(4'h5, 0, 2));
    poke(7, enc(4'h2, 1, 'h100));
    poke(8, enc(4'h0, 0, 0));
    poke('h101, b);
    poke('h102, c);
    poke('h201, 16'd1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL global watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc, c0, ck, cn;
    logic [DW-1:0] b, c, x, s;
    void'($urandom(32'd20240611));

    // R1: reset state
    hold_reset();
    repeat (2) @(negedge clk);
    check(halted == 1'b0 && mem_we == 1'b0 && mem_addr == '0, "R1 reset outputs",
          {halted, mem_we, mem_addr}, 0);

    // R4 R5 R7 R10: multiply by repeated addition
    load_mult(16'h1234, 16'd0);
    rst_n = 1'b1; #1;
    check(mem_addr == '0 && !mem_we, "R1 first fetch at 0", mem_addr, 0);
    run(c0);
    check(mem['h100] == 16'h0, "R7 mult count zero", mem['h100], 0);
    load_mult(16'h0042, 16'hFFFD);
    run(cn);
    check(mem['h100] == 16'h0, "R7 mult count negative", mem['h100], 0);
    check(cn - c0 == 3, "R10 IFNEG cost", cn - c0, 3);
    for (int t = 0; t < 8; t++) begin
      b = DW'($urandom);
      c = DW'($urandom_range(1, 20));
      load_mult(b, c);
      run(ck);
      check(mem['h100] == mul_ref(b, c), "R5 mult product", mem['h100], mul_ref(b, c));
      check(ck - c0 == 19 * int'(c), "R10 loop cycles", ck - c0, 19 * int'(c));
    end

    // R8: vector sum with pointer walk
    for (int t = 0; t < 4; t++) begin
      int n = $urandom_range(1, 16);
      hold_reset();
      poke(0, enc(4'h5, 0, 'h10));
      poke(2, 16'd1);
      poke(3, DW'(n));
      poke(4, 16'h200);
      poke('h10, enc(4'h1, 0, 1));
      poke('h11, enc(4'h1, 1, 3));
      poke('h12, enc(4'h1, 2, 4));
      poke('h13, enc(4'h6, 1, 'h19));
      poke('h14, enc(4'h7, 1, 'h19));
      poke('h15, enc(4'hB, 0, 2));
      poke('h16, enc(4'h3, 2, 2));
      poke('h17, enc(4'h4, 1, 2));
      poke('h18, enc(4'h5, 0, 'h13));
      poke('h19, enc(4'h2, 0, 5));
      poke('h1A, enc(4'h0, 0, 0));
      s = '0;
      for (int i = 0; i < n; i++) begin
        x = DW'($urandom);
        s = s + x;
        poke('h200 + i, x);
      end
      run(cyc);
      check(mem[5] == s, "R8 vector sum", mem[5], s);
    end

    // R8 R4 R7: indirect store/subtract, branch on sign
    for (int t = 0; t < 3; t++) begin
      x = (t == 0) ? 16'h8000 : (t == 1) ? 16'h7FFF : DW'($urandom);
      hold_reset();
      poke(0, enc(4'h1, 3, 'h40));
      poke(1, enc(4'h9, 1, 3));
      poke(2, enc(4'hC, 1, 3));
      poke(3, enc(4'h2, 1, 'h41));
      poke(4, enc(4'h1, 2, 'h42));
      poke(5, enc(4'hA, 2, 3));
      poke(6, enc(4'h7, 2, 9));
      poke(7, enc(4'h2, 2, 'h43));
      poke(8, enc(4'h0, 0, 0));
      poke(9, enc(4'h2, 3, 'h44));
      poke(10, enc(4'hD, 0, 0));
      poke('h40, 16'h0300);
      poke('h41, 16'hFFFF);
      poke('h42, x);
      poke('h300, 16'h5A5A);
      run(cyc);
      check(mem['h41] == 16'h0, "R8 indirect sub", mem['h41], 0);
      check(mem['h300] == x, "R8 indirect store", mem['h300], x);
      if (x[15]) begin
        check(mem['h44] == 16'h0300 && mem['h43] == 0, "R7 IFNEG taken", mem['h44], 'h300);
      end else begin
        check(mem['h43] == x && mem['h44] == 0, "R7 IFNEG fall-through", mem['h43], x);
      end
    end

    // R9: every halting opcode stops and freezes
    for (int t = 0; t < 5; t++) begin
      logic [3:0] op = (t == 0) ? 4'h0 : (t == 1) ? 4'h8 : 4'(4'hD + t - 2);
      hold_reset();
      poke(0, enc(4'h1, 1, 'h60));
      poke(1, enc(op, 1, 'h50));
      poke(2, enc(4'h2, 1, 'h50));
      poke('h60, 16'hBEEF);
      run(cyc);
      repeat (20) begin
        @(negedge clk);
        check(!mem_we && mem_addr == AW'(2), "R9 frozen after halt", mem_addr, 2);
      end
      check(mem['h50] == 16'h0, "R9 no execution past halt", mem['h50], 0);
    end

    // R2 R3 R6: counter wrap from last word and jump to it
    hold_reset();
    poke(0, enc(4'h7, 1, 2));
    poke(1, enc(4'h5, 0, 'h3FF));
    poke(2, enc(4'h2, 1, 'h50));
    poke(3, enc(4'h0, 0, 0));
    poke('h3FF, enc(4'h1, 1, 'h60));
    poke('h60, 16'h8000);
    run(cyc);
    check(mem['h50] == 16'h8000, "R2 pc wrap", mem['h50], 'h8000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule